// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Slice

This block is one output slice of a small programmable logic array. A bank of input signals is expanded into true and complement literals. A static AND mask, held in configuration, builds up to eight product terms from those literals. A fixed OR reduces the product terms to a single sum, and the sum enters an output macrocell.

The macrocell is steered by a two-bit global mode, shared by every slice of the array, and one local bit per slice. Together they choose four things:
- whether the pin is driven from a flop or directly from the sum,
- where the tristate enable comes from,
- whether product term 0 is spent as the enable,
- what value is returned to the array as feedback.

A per-slice polarity bit can invert the output. The flop clears under a synchronous reset, which models the clear at power-up. A preload strobe can force any value into the flop for testing.

Top module: `sop_macrocell`

## Requirements
- R1: Product term t is the AND of the literals that its mask slice selects. The slice is `and_mask[t*2*NUM_IN +: 2*NUM_IN]`. In that slice, bit 2i selects input i true and bit 2i+1 selects input i complemented.
- R2: A product term evaluates to 0 when its mask selects no literal. It also evaluates to 0 when its mask selects both the true and the complement literal of one input.
- R3: When term 0 is not used as the enable, the sum is the OR of all eight terms. When term 0 is the enable, the sum is the OR of terms 1 to 7.
- R4: With `pol_inv`=1 the output value is the inverted sum. With `pol_inv`=0 it is the sum unchanged.
- R5: Mode 2'b10 with local bit 1 gives a registered output. `pin_out` shows the flop, which loads the polarised sum at every clock edge. `pin_oe` is the inverse of `oe_n`, and the feedback is the flop value.
- R6: Mode 2'b10 with local bit 0 gives a combinational output enabled by term 0.
- R7: Mode 2'b01 with local bit 1 gives a combinational output that is always enabled.
- R8: Mode 2'b01 with local bit 0 makes the pin an input. `pin_oe` is 0 and the feedback is `pin_in`.
- R9: Mode 2'b11 gives a combinational output enabled by term 0 whatever the local bit is. In this mode the sum covers terms 1 to 7.
- R10: The reserved mode 2'b00 keeps the output disabled, and the feedback is `pin_in`.
- R11: A `preload_en` sampled high at a clock edge loads `preload_val` into the flop instead of the sum.
- R12: `rst_n` low at a clock edge clears the flop to 0, even while `preload_en` is high.
- R13: In every configuration that does not drive the pin from the flop, the feedback is the pin value. That value is `pin_out` when `pin_oe`=1 and `pin_in` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output flop |
| rst_n | input | 1 | Synchronous active-low reset; clears the flop |
| in_vec | input | NUM_IN | Array input signals |
| and_mask | input | NUM_TERMS*2*NUM_IN | Static literal-select mask for all product terms |
| gmode | input | 2 | Global mode shared by every slice |
| local_cfg | input | 1 | Local mode bit of this slice |
| pol_inv | input | 1 | 1 inverts the output value |
| oe_n | input | 1 | Shared active-low enable used by registered slices |
| preload_en | input | 1 | Test strobe: load `preload_val` at the next edge |
| preload_val | input | 1 | Value forced into the flop by preload |
| pin_in | input | 1 | Level seen on the pin when this slice does not drive it |
| pin_out | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Tristate enable of the pin |
| fb_out | output | 1 | Feedback returned to the array |

## Verification
Every combinational result is due in the same cycle as its stimulus. These results are the product terms, the sum, the polarity, `pin_oe` and the feedback in non-registered modes. The bench drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. The flop path is one edge deep: a value presented before a rising edge, whether sum, preload or reset, appears on `pin_out` and `fb_out` after that edge. The bench therefore checks it at the following falling edge. Just after a drive, it also confirms that `pin_out` still holds the old flop value.

// File: rtl/sop_pkg.sv
// Shared types for the sum-of-products output slice.
// Assumes: the global mode encoding is fixed for the whole array.
package sop_pkg;

    typedef enum logic [1:0] {
        GM_RESERVED = 2'b00,
        GM_SIMPLE   = 2'b01,
        GM_REGBANK  = 2'b10,
        GM_COMPLEX  = 2'b11
    } gmode_e;

    typedef enum logic [1:0] {
        EN_NEVER  = 2'b00,
        EN_ALWAYS = 2'b01,
        EN_OE_PIN = 2'b10,
        EN_TERM0  = 2'b11
    } en_src_e;

    typedef struct packed {
        logic    reg_path;    // pin driven from the flop
        logic    pt0_enable;  // term 0 spent as enable, not summed
        en_src_e en_src;      // source of the tristate enable
    } slice_ctl_t;

endpackage

// File: rtl/sop_pterm.sv
// One product term: AND of the literals its mask selects.
// Assumes: mask bit 2i picks input i true, bit 2i+1 picks it complemented.
// An empty mask yields 0, as does an erased array.
module sop_pterm #(
    parameter int NUM_IN = 16
) (
    input  logic [NUM_IN-1:0]   in_vec,
    input  logic [2*NUM_IN-1:0] mask,
    output logic                term
);
    localparam int NUM_LIT = 2 * NUM_IN;

    logic [NUM_LIT-1:0] lits;

    // Interleave true and complement literals for every input.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
        assign lits[2*i]   = in_vec[i];
        assign lits[2*i+1] = ~in_vec[i];
    end

    logic all_hit;
    logic any_sel;

    // Reduce the selected literals and detect an empty mask.
    always_comb begin
        all_hit = &(lits | ~mask);
        any_sel = |mask;
        term    = all_hit & any_sel;
    end

endmodule

// File: rtl/sop_mode_dec.sv
// Decodes global mode and local bit into the macrocell steering controls.
// Assumes: the reserved global code leaves the output disabled.
module sop_mode_dec
    import sop_pkg::*;
(
    input  logic [1:0] gmode,
    input  logic       local_cfg,
    output slice_ctl_t ctl
);
    // Map each mode/local pair onto path, enable source and term-0 use.
    always_comb begin
        ctl = '{reg_path: 1'b0, pt0_enable: 1'b0, en_src: EN_NEVER};
        case (gmode_e'(gmode))
            GM_REGBANK: begin
                if (local_cfg) begin
                    ctl.reg_path = 1'b1;
                    ctl.en_src   = EN_OE_PIN;
                end else begin
                    ctl.pt0_enable = 1'b1;
                    ctl.en_src     = EN_TERM0;
                end
            end
            GM_SIMPLE: begin
                ctl.en_src = local_cfg ? EN_ALWAYS : EN_NEVER;
            end
            GM_COMPLEX: begin
                ctl.pt0_enable = 1'b1;
                ctl.en_src     = EN_TERM0;
            end
            default: begin
                ctl.en_src = EN_NEVER;
            end
        endcase
    end

endmodule

// File: rtl/sop_sum_sel.sv
// Fixed OR of the product terms; term 0 is left out when it drives the enable.
// Assumes: NUM_TERMS is at least 2.
module sop_sum_sel #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms,
    input  logic                 pt0_enable,
    output logic                 sum,
    output logic                 en_term
);
    logic upper_or;

    // OR the upper terms and fold in term 0 only when it is not the enable.
    always_comb begin
        upper_or = |terms[NUM_TERMS-1:1];
        sum      = upper_or | (terms[0] & ~pt0_enable);
        en_term  = terms[0];
    end

endmodule

// File: rtl/sop_out_reg.sv
// Output flop with synchronous clear and test preload.
// Assumes: reset outranks preload, and preload outranks the array data.
module sop_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic preload_en,
    input  logic preload_val,
    input  logic d,
    output logic q
);
    // Capture reset, preload or array data in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (preload_en) begin
            q <= preload_val;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sop_macrocell.sv
// Top of one output slice: product terms, fixed OR, and the macrocell
// that chooses path, polarity, enable and feedback.
// Assumes: and_mask, gmode, local_cfg and pol_inv are static configuration.
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int NUM_IN    = 16,
    parameter int NUM_TERMS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_IN-1:0]             in_vec,
    input  logic [NUM_TERMS*2*NUM_IN-1:0] and_mask,
    input  logic [1:0]                    gmode,
    input  logic                          local_cfg,
    input  logic                          pol_inv,
    input  logic                          oe_n,
    input  logic                          preload_en,
    input  logic                          preload_val,
    input  logic                          pin_in,
    output logic                          pin_out,
    output logic                          pin_oe,
    output logic                          fb_out
);
    localparam int MASK_W = 2 * NUM_IN;

    logic [NUM_TERMS-1:0] term_vec;
    slice_ctl_t           ctl;
    logic                 sum_raw;
    logic                 term0;
    logic                 data_pol;
    logic                 q_r;

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        sop_pterm #(.NUM_IN(NUM_IN)) u_pterm (
            .in_vec (in_vec),
            .mask   (and_mask[t*MASK_W +: MASK_W]),
            .term   (term_vec[t])
        );
    end

    sop_mode_dec u_dec (
        .gmode     (gmode),
        .local_cfg (local_cfg),
        .ctl       (ctl)
    );

    sop_sum_sel #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .terms      (term_vec),
        .pt0_enable (ctl.pt0_enable),
        .sum        (sum_raw),
        .en_term    (term0)
    );

    // Apply the per-slice polarity.
    always_comb begin
        data_pol = sum_raw ^ pol_inv;
    end

    sop_out_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .d           (data_pol),
        .q           (q_r)
    );

    // Select the pin value, its enable and the feedback to the array.
    always_comb begin
        pin_out = ctl.reg_path ? q_r : data_pol;
        case (ctl.en_src)
            EN_ALWAYS: pin_oe = 1'b1;
            EN_OE_PIN: pin_oe = ~oe_n;
            EN_TERM0:  pin_oe = term0;
            default:   pin_oe = 1'b0;
        endcase
        fb_out = ctl.reg_path ? q_r : (pin_oe ? pin_out : pin_in);
    end

endmodule

// File: rtl/sop_macrocell_chk.sv
// Temporal checks for sop_macrocell, attached by bind.
// Assumes: it sees the internal flop, the polarised data and term 0.
module sop_macrocell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] gmode,
    input logic       local_cfg,
    input logic       oe_n,
    input logic       preload_en,
    input logic       preload_val,
    input logic       pin_in,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       fb_out,
    input logic       q_r,
    input logic       data_pol,
    input logic       term0
);
    logic reg_cfg;
    assign reg_cfg = (gmode == 2'b10) && local_cfg;

    a_r12_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q_r == 1'b0));

    a_r11_preload_loads: assert property (@(posedge clk) disable iff (!rst_n)
        preload_en |=> (q_r == $past(preload_val)));

    a_r5_captures_data: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en |=> (q_r == $past(data_pol)));

    a_r5_enable_from_oe: assert property (@(posedge clk) disable iff (!rst_n)
        reg_cfg |-> (pin_oe == !oe_n));

    a_r5_feedback_is_q: assert property (@(posedge clk) disable iff (!rst_n)
        reg_cfg |-> (fb_out == q_r));

    a_r7_always_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ((gmode == 2'b01) && local_cfg) |-> pin_oe);

    a_r8_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        ((gmode == 2'b01) && !local_cfg) |-> (!pin_oe && (fb_out == pin_in)));

    a_r9_term0_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode == 2'b11) |-> (pin_oe == term0));

    a_r10_reserved_off: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode == 2'b00) |-> !pin_oe);

    a_r13_feedback_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_cfg |-> (fb_out == (pin_oe ? pin_out : pin_in)));

endmodule

bind sop_macrocell sop_macrocell_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gmode       (gmode),
    .local_cfg   (local_cfg),
    .oe_n        (oe_n),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .fb_out      (fb_out),
    .q_r         (q_r),
    .data_pol    (data_pol),
    .term0       (term0)
);

// File: tb/sop_macrocell_bench.sv
`timescale 1ns/1ps
// Directed bench for sop_macrocell with a behavioural model.
module sop_macrocell_bench;
    localparam int NI = 16;
    localparam int NT = 8;
    localparam int MW = 2 * NI;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] in_vec = '0;
    logic [NT*MW-1:0] and_mask = '0;
    logic [1:0]    gmode = 2'b10;
    logic          local_cfg = 1'b1;
    logic          pol_inv = 1'b0;
    logic          oe_n = 1'b0;
    logic          preload_en = 1'b0;
    logic          preload_val = 1'b0;
    logic          pin_in = 1'b0;
    logic          pin_out, pin_oe, fb_out;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sop_macrocell #(.NUM_IN(NI), .NUM_TERMS(NT)) u_sop_macrocell (
        .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .and_mask(and_mask),
        .gmode(gmode), .local_cfg(local_cfg), .pol_inv(pol_inv), .oe_n(oe_n),
        .preload_en(preload_en), .preload_val(preload_val), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    task automatic chk(string req, string what, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // Model of one product term, literal by literal.
    function automatic logic m_term(logic [MW-1:0] m, logic [NI-1:0] v);
        logic any = 1'b0;
        for (int i = 0; i < NI; i++) begin
            if (m[2*i]) begin
                any = 1'b1;
                if (!v[i]) return 1'b0;
            end
            if (m[2*i+1]) begin
                any = 1'b1;
                if (v[i]) return 1'b0;
            end
        end
        return any;
    endfunction

    function automatic logic m_sum(logic [NT*MW-1:0] m, logic [NI-1:0] v, bit skip0);
        logic s = 1'b0;
        for (int t = (skip0 ? 1 : 0); t < NT; t++) s |= m_term(m[t*MW +: MW], v);
        return s;
    endfunction

    function automatic logic [MW-1:0] rnd_term();
        logic [MW-1:0] m = '0;
        int kind = $urandom_range(0, 9);
        if (kind == 0) return m;
        if (kind == 1) begin
            int k = $urandom_range(0, NI-1);
            m[2*k] = 1'b1;
            m[2*k+1] = 1'b1;
            return m;
        end
        for (int n = 0; n < $urandom_range(1, 2); n++) begin
            int k = $urandom_range(0, NI-1);
            m[2*k + $urandom_range(0, 1)] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [NT*MW-1:0] rnd_mask();
        logic [NT*MW-1:0] m;
        for (int t = 0; t < NT; t++) m[t*MW +: MW] = rnd_term();
        return m;
    endfunction

    task automatic drive_rand(bit keep_pol);
        and_mask = rnd_mask();
        in_vec   = NI'($urandom);
        pin_in   = 1'($urandom);
        if (!keep_pol) pol_inv = 1'($urandom);
    endtask

    // R12: clear on reset, also with preload high.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; gmode = 2'b10; local_cfg = 1'b1; oe_n = 1'b0;
        preload_en = 1'b1; preload_val = 1'b1;
        @(negedge clk);
        chk("R12", "pin_out in reset", pin_out, 1'b0);
        chk("R12", "fb_out in reset", fb_out, 1'b0);
        preload_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 R2 R3 R7 R13: combinational always-on output.
    task automatic t_terms();
        @(negedge clk);
        gmode = 2'b01; local_cfg = 1'b1; pol_inv = 1'b0;
        and_mask = '0;
        #1 chk("R2", "all masks empty", pin_out, 1'b0);
        and_mask[0*MW + 2*3] = 1'b1;
        and_mask[0*MW + 2*5 + 1] = 1'b1;
        in_vec = '0; in_vec[3] = 1'b1;
        #1 chk("R1", "term0 in3 & ~in5 true", pin_out, 1'b1);
        in_vec[5] = 1'b1;
        #1 chk("R1", "term0 in3 & ~in5 false", pin_out, 1'b0);
        and_mask = '0;
        and_mask[4*MW + 2*2] = 1'b1;
        and_mask[4*MW + 2*2 + 1] = 1'b1;
        in_vec[2] = 1'b1;
        #1 chk("R2", "conflict term in2 high", pin_out, 1'b0);
        in_vec[2] = 1'b0;
        #1 chk("R2", "conflict term in2 low", pin_out, 1'b0);
        and_mask = '0;
        and_mask[0*MW + 2*0] = 1'b1;
        in_vec = '0; in_vec[0] = 1'b1;
        #1 chk("R3", "term0 alone summed", pin_out, 1'b1);
        for (int it = 0; it < 30; it++) begin
            @(negedge clk);
            drive_rand(1'b1);
            #1;
            chk("R1", "random sum of eight", pin_out, m_sum(and_mask, in_vec, 1'b0));
            chk("R7", "always enabled", pin_oe, 1'b1);
            chk("R13", "feedback is driven pin", fb_out, pin_out);
        end
    endtask

    // R4: polarity inversion.
    task automatic t_polarity();
        @(negedge clk);
        gmode = 2'b01; local_cfg = 1'b1; pol_inv = 1'b1;
        for (int it = 0; it < 20; it++) begin
            @(negedge clk);
            drive_rand(1'b1);
            #1 chk("R4", "inverted output", pin_out, ~m_sum(and_mask, in_vec, 1'b0));
        end
    endtask

    // R6 R9 R3 R13: term 0 as enable.
    task automatic t_term0_enable(logic [1:0] gm, string req);
        @(negedge clk);
        gmode = gm; local_cfg = 1'b0; pol_inv = 1'b0;
        and_mask = '0; and_mask[0*MW + 2*0] = 1'b1;
        in_vec = '0; in_vec[0] = 1'b1;
        #1;
        chk("R3", "term0 excluded from sum", pin_out, 1'b0);
        chk(req, "term0 enables", pin_oe, 1'b1);
        for (int it = 0; it < 30; it++) begin
            @(negedge clk);
            drive_rand(1'b0);
            if (gm == 2'b11) local_cfg = 1'($urandom);
            #1;
            chk(req, "value sum of seven", pin_out,
                m_sum(and_mask, in_vec, 1'b1) ^ pol_inv);
            chk(req, "enable is term0", pin_oe, m_term(and_mask[MW-1:0], in_vec));
            chk("R13", "feedback pin value", fb_out, pin_oe ? pin_out : pin_in);
        end
    endtask

    // R8 R10: output released, feedback from pin.
    task automatic t_released(logic [1:0] gm, string req);
        @(negedge clk);
        gmode = gm; local_cfg = 1'b0;
        for (int it = 0; it < 12; it++) begin
            @(negedge clk);
            drive_rand(1'b0);
            if (gm == 2'b00) local_cfg = 1'($urandom);
            #1;
            chk(req, "output disabled", pin_oe, 1'b0);
            chk(req, "feedback is pin_in", fb_out, pin_in);
        end
    endtask

    // R5: registered path, one edge deep.
    task automatic t_registered();
        logic exp_q;
        @(negedge clk);
        gmode = 2'b10; local_cfg = 1'b1; preload_en = 1'b0;
        drive_rand(1'b0);
        exp_q = m_sum(and_mask, in_vec, 1'b0) ^ pol_inv;
        for (int it = 0; it < 30; it++) begin
            @(negedge clk);
            chk("R5", "flop after edge", pin_out, exp_q);
            chk("R5", "feedback is flop", fb_out, exp_q);
            drive_rand(1'b0);
            oe_n = 1'($urandom);
            #1;
            chk("R5", "flop holds before edge", pin_out, exp_q);
            chk("R5", "enable from oe_n", pin_oe, ~oe_n);
            exp_q = m_sum(and_mask, in_vec, 1'b0) ^ pol_inv;
        end
        @(negedge clk);
        chk("R5", "final flop value", pin_out, exp_q);
    endtask

    // R11 R12: preload priority, then reset during operation.
    task automatic t_preload();
        @(negedge clk);
        gmode = 2'b10; local_cfg = 1'b1; oe_n = 1'b0;
        and_mask = '0; pol_inv = 1'b0;
        preload_en = 1'b1; preload_val = 1'b1;
        @(negedge clk);
        chk("R11", "preload 1 over data 0", pin_out, 1'b1);
        preload_en = 1'b0;
        @(negedge clk);
        chk("R11", "data resumes after preload", pin_out, 1'b0);
        pol_inv = 1'b1; preload_en = 1'b1; preload_val = 1'b0;
        @(negedge clk);
        chk("R11", "preload 0 over data 1", pin_out, 1'b0);
        for (int it = 0; it < 10; it++) begin
            drive_rand(1'b0);
            preload_val = 1'($urandom);
            @(negedge clk);
            chk("R11", "random preload", pin_out, preload_val);
        end
        preload_val = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12", "reset beats preload", pin_out, 1'b0);
        preload_en = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_terms();
        t_polarity();
        t_term0_enable(2'b10, "R6");
        t_term0_enable(2'b11, "R9");
        t_released(2'b01, "R8");
        t_released(2'b00, "R10");
        t_registered();
        t_preload();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule